// File: doc/BRIEF.md
# Minimal Pipelined Accumulator CPU Core

This block is a 16-bit accumulator processor core. One word-addressed memory port carries both instruction fetches and data traffic. Programmers see an accumulator, a program counter, a temporary register that supplies the data for indirect stores, and carry and zero flags. Each instruction is one 16-bit word. The top four bits select the operation and the low twelve bits give a direct address. Through that address the core reaches operands, jump vectors and pointer words in the low 4K words. The full 64K-word space is reachable only through the pointer and vector words.

The core overlaps work. While an instruction executes, the address of the next instruction is already on the memory port. The core has no separate incrementer for the program counter. In the cycle where the direct operand is being read, the single ALU adds one to the program counter. The accumulator and program counter trade places on the ALU inputs for that step. The core runs without stopping from reset onwards. It has no stack, no call instruction and no interrupt support.

Top module: `acc16_core`

## Requirements
- R1: On reset, PC, A and T become 0x0000 and C becomes 0. Z becomes 1, consistent with A being zero. In the first cycle after reset is released, the core presents address 0x0000 with write enable low.
- R2: Bits [15:12] of an instruction select the operation and bits [11:0] give the direct address, zero-extended to 16 bits. The opcodes are: 0 add, 1 subtract with borrow, 2 xor, 3 or, 4 and, 5 rotate right through carry, 6 load with carry clear, 7 load with carry kept, 8 copy A to T, 9 jump if carry clear, 10 jump if not zero, 11 load indirect, 12 store indirect.
- R3: Add (0) sets A to A plus the direct operand, and C to the carry out of bit 15.
- R4: Subtract (1) sets A to A minus the operand minus C. C becomes 1 exactly when the true result is negative (a borrow).
- R5: Xor (2), or (3) and and (4) combine A with the operand bitwise and leave C unchanged.
- R6: Rotate (5) turns {A,C} right by one as a 17-bit value. A becomes {C, A[15:1]} and C becomes the old A[0]. The operand word is ignored.
- R7: Load (6) sets A to the operand and clears C. Load (7) sets A to the operand and keeps C.
- R8: Copy (8) sets T to A. Store indirect (12) writes T to the 16-bit address held in the direct-addressed word. No other instruction drives write enable.
- R9: Jump (9) is taken when C=0. A taken jump sets PC to the 16-bit vector word at the direct address. When C=1, execution continues with the next word.
- R10: Jump (10) is taken when Z=0, with the same vector rule as R9.
- R11: Load indirect (11) sets A to the word at the 16-bit address held in the direct-addressed word and leaves C unchanged.
- R12: Every instruction that writes A also sets Z to (A == 0), including rotate and the logic operations.
- R13: An instruction that neither stores nor loads indirectly takes two cycles. The next instruction's address is on the port during the execute cycle, and PC advances by one during the operand read cycle. A store-indirect instruction drives write enable in its second cycle after its own fetch.
- R14: Opcodes 13, 14 and 15 change none of A, T, C or Z, and execution continues with the next word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 16 | Word address for the current memory access |
| mem_rdata | input | 16 | Read data, valid one cycle after its address |
| mem_wdata | output | 16 | Write data (the T register) |
| mem_we | output | 1 | Write enable for mem_addr this cycle |

## Verification
Several rules are checked in every cycle:
- Z always tracks A being zero.
- The program counter advances by exactly one in every decode cycle.
- Write enable appears only while a store-indirect executes.
- The logic operations and the unassigned opcodes leave the carry alone.
- A load-with-clear zeroes the carry.
- An indirect load delivers the fetched word into A.
- Copy moves A into T.

Only the bench programs can show the following:
- The arithmetic values, including carry and borrow in and out.
- The 17-bit rotation sequence.
- Whether each conditional jump is taken or falls through.
- Full 16-bit indirect addressing.
- Zero extension of the direct field.
- The exact cycle in which a store reaches the port.

// File: rtl/acc16_pkg.sv
package acc16_pkg;

    localparam int WORD_W = 16;
    localparam int OPC_W  = 4;
    localparam int DIR_W  = WORD_W - OPC_W;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [OPC_W-1:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_XOR  = 4'd2,
        OP_OR   = 4'd3,
        OP_AND  = 4'd4,
        OP_RRC  = 4'd5,
        OP_LDC  = 4'd6,
        OP_LDK  = 4'd7,
        OP_TAT  = 4'd8,
        OP_JCC  = 4'd9,
        OP_JNZ  = 4'd10,
        OP_LDI  = 4'd11,
        OP_STI  = 4'd12,
        OP_N13  = 4'd13,
        OP_N14  = 4'd14,
        OP_N15  = 4'd15
    } opcode_e;

    typedef enum logic [1:0] {
        ST_FETCH,
        ST_DECODE,
        ST_EXEC,
        ST_INDIR
    } state_e;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_XOR,
        ALU_OR,
        ALU_AND,
        ALU_RRC,
        ALU_PASS
    } alu_op_e;

    typedef enum logic [1:0] {
        C_KEEP,
        C_ALU,
        C_CLEAR
    } c_src_e;

    typedef struct packed {
        alu_op_e alu_op;
        logic    wr_a;
        c_src_e  c_src;
        logic    wr_t;
        logic    jmp_c;
        logic    jmp_nz;
        logic    ld_ind;
        logic    st_ind;
    } ctrl_t;

    typedef struct packed {
        state_e  state;
        word_t   pc;
        word_t   a;
        word_t   t;
        logic    c;
        logic    z;
        opcode_e op;
    } core_t;

endpackage

// File: rtl/acc16_alu.sv
module acc16_alu
    import acc16_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  alu_op_e      op,
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         cout
);

    logic [W:0] wide_sum;
    logic [W:0] wide_dif;

    always_comb begin
        wide_sum = {1'b0, x} + {1'b0, y};
        wide_dif = {1'b0, x} - {1'b0, y} - {{W{1'b0}}, cin};
        res      = y;
        cout     = cin;
        case (op)
            ALU_ADD: begin
                res  = wide_sum[W-1:0];
                cout = wide_sum[W];
            end
            ALU_SUB: begin
                res  = wide_dif[W-1:0];
                cout = wide_dif[W];
            end
            ALU_XOR: res = x ^ y;
            ALU_OR:  res = x | y;
            ALU_AND: res = x & y;
            ALU_RRC: begin
                res  = {cin, x[W-1:1]};
                cout = x[0];
            end
            default: begin
                res  = y;
                cout = cin;
            end
        endcase
    end

endmodule

// File: rtl/acc16_decode.sv
module acc16_decode
    import acc16_pkg::*;
(
    input  opcode_e op,
    output ctrl_t   ctrl
);

    always_comb begin
        ctrl        = '0;
        ctrl.alu_op = ALU_PASS;
        ctrl.c_src  = C_KEEP;
        case (op)
            OP_ADD: begin
                ctrl.alu_op = ALU_ADD;
                ctrl.wr_a   = 1'b1;
                ctrl.c_src  = C_ALU;
            end
            OP_SUB: begin
                ctrl.alu_op = ALU_SUB;
                ctrl.wr_a   = 1'b1;
                ctrl.c_src  = C_ALU;
            end
            OP_XOR: begin
                ctrl.alu_op = ALU_XOR;
                ctrl.wr_a   = 1'b1;
            end
            OP_OR: begin
                ctrl.alu_op = ALU_OR;
                ctrl.wr_a   = 1'b1;
            end
            OP_AND: begin
                ctrl.alu_op = ALU_AND;
                ctrl.wr_a   = 1'b1;
            end
            OP_RRC: begin
                ctrl.alu_op = ALU_RRC;
                ctrl.wr_a   = 1'b1;
                ctrl.c_src  = C_ALU;
            end
            OP_LDC: begin
                ctrl.wr_a  = 1'b1;
                ctrl.c_src = C_CLEAR;
            end
            OP_LDK: ctrl.wr_a   = 1'b1;
            OP_TAT: ctrl.wr_t   = 1'b1;
            OP_JCC: ctrl.jmp_c  = 1'b1;
            OP_JNZ: ctrl.jmp_nz = 1'b1;
            OP_LDI: ctrl.ld_ind = 1'b1;
            OP_STI: ctrl.st_ind = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/acc16_core.sv
module acc16_core
    import acc16_pkg::*;
#(
    parameter logic [WORD_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [WORD_W-1:0] mem_addr,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              mem_we
);

    localparam int EXT_W = WORD_W - DIR_W;

    core_t   q;
    core_t   d;
    ctrl_t   ctrl;
    alu_op_e alu_sel;
    word_t   alu_x;
    word_t   alu_y;
    logic    alu_cin;
    word_t   alu_res;
    logic    alu_cout;
    word_t   dir_addr;
    logic    taken;

    acc16_decode u_dec (
        .op   (q.op),
        .ctrl (ctrl)
    );

    // Operand routing: the PC takes the accumulator's place while decoding.
    always_comb begin
        if (q.state == ST_DECODE) begin
            alu_sel = ALU_ADD;
            alu_x   = q.pc;
            alu_y   = word_t'(1);
            alu_cin = 1'b0;
        end else begin
            alu_sel = ctrl.alu_op;
            alu_x   = q.a;
            alu_y   = mem_rdata;
            alu_cin = q.c;
        end
    end

    acc16_alu #(.W(WORD_W)) u_alu (
        .op   (alu_sel),
        .x    (alu_x),
        .y    (alu_y),
        .cin  (alu_cin),
        .res  (alu_res),
        .cout (alu_cout)
    );

    always_comb begin
        d         = q;
        mem_addr  = q.pc;
        mem_we    = 1'b0;
        mem_wdata = q.t;
        dir_addr  = {{EXT_W{1'b0}}, mem_rdata[DIR_W-1:0]};
        taken     = (ctrl.jmp_c & ~q.c) | (ctrl.jmp_nz & ~q.z);
        case (q.state)
            ST_FETCH: begin
                mem_addr = q.pc;
                d.state  = ST_DECODE;
            end
            ST_DECODE: begin
                d.op     = opcode_e'(mem_rdata[WORD_W-1:DIR_W]);
                mem_addr = dir_addr;
                d.pc     = alu_res;
                d.state  = ST_EXEC;
            end
            ST_EXEC: begin
                if (ctrl.wr_a) begin
                    d.a = alu_res;
                    d.z = (alu_res == '0);
                end
                case (ctrl.c_src)
                    C_ALU:   d.c = alu_cout;
                    C_CLEAR: d.c = 1'b0;
                    default: d.c = q.c;
                endcase
                if (ctrl.wr_t) begin
                    d.t = q.a;
                end
                if (taken) begin
                    d.pc     = mem_rdata;
                    mem_addr = mem_rdata;
                    d.state  = ST_DECODE;
                end else if (ctrl.ld_ind) begin
                    mem_addr = mem_rdata;
                    d.state  = ST_INDIR;
                end else if (ctrl.st_ind) begin
                    mem_addr = mem_rdata;
                    mem_we   = 1'b1;
                    d.state  = ST_FETCH;
                end else begin
                    mem_addr = q.pc;
                    d.state  = ST_DECODE;
                end
            end
            ST_INDIR: begin
                d.a      = mem_rdata;
                d.z      = (mem_rdata == '0);
                mem_addr = q.pc;
                d.state  = ST_DECODE;
            end
            default: d.state = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state <= ST_FETCH;
            q.pc    <= RESET_PC;
            q.a     <= '0;
            q.t     <= '0;
            q.c     <= 1'b0;
            q.z     <= 1'b1;
            q.op    <= OP_N15;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/acc16_core_chk.sv
module acc16_core_chk
    import acc16_pkg::*;
(
    input logic  clk,
    input logic  rst_n,
    input core_t cur,
    input logic  mem_we,
    input word_t mem_rdata
);

    // R12: zero flag mirrors the accumulator
    p_zero_track_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cur.z == (cur.a == '0));

    // R13: the shared ALU steps the PC in each decode cycle
    p_pc_step_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (cur.state == ST_DECODE) |=> (cur.pc == $past(cur.pc) + 16'd1));

    // R8: only a store-indirect in its execute cycle writes
    p_write_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (cur.state == ST_EXEC && cur.op == OP_STI));

    // R8: copy moves A into T
    p_copy_t_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cur.state == ST_EXEC && cur.op == OP_TAT) |=> (cur.t == $past(cur.a)));

    // R5: logic operations leave C alone
    p_logic_keep_c_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cur.state == ST_EXEC && (cur.op == OP_XOR || cur.op == OP_OR || cur.op == OP_AND))
        |=> $stable(cur.c));

    // R7: load with clear zeroes C
    p_load_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cur.state == ST_EXEC && cur.op == OP_LDC) |=> !cur.c);

    // R11: the indirect read lands in A
    p_ind_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cur.state == ST_INDIR) |=> (cur.a == $past(mem_rdata)));

    // R14: spare opcodes keep A and C
    p_spare_nop_r14: assert property (@(posedge clk) disable iff (!rst_n)
        (cur.state == ST_EXEC && (cur.op == OP_N13 || cur.op == OP_N14 || cur.op == OP_N15))
        |=> ($stable(cur.a) && $stable(cur.c)));

endmodule

bind acc16_core acc16_core_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cur       (q),
    .mem_we    (mem_we),
    .mem_rdata (mem_rdata)
);

// File: tb/acc16_core_tb.sv
module acc16_core_tb;

    // Opcode values from R2
    localparam logic [3:0] K_ADD = 4'd0,  K_SUB = 4'd1,  K_XOR = 4'd2,  K_OR  = 4'd3;
    localparam logic [3:0] K_AND = 4'd4,  K_RRC = 4'd5,  K_LDC = 4'd6,  K_LDK = 4'd7;
    localparam logic [3:0] K_TAT = 4'd8,  K_JCC = 4'd9,  K_JNZ = 4'd10, K_LDI = 4'd11;
    localparam logic [3:0] K_STI = 4'd12;

    typedef struct {
        logic [15:0] addr;
        logic [15:0] data;
        int          cyc;
        string       req;
    } wr_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr;
    logic [15:0] mem_rdata = '0;
    logic [15:0] mem_wdata;
    logic        mem_we;

    logic [15:0] mem [logic [15:0]];
    wr_item_t    exp_q [$];
    int          checks = 0;
    int          errors = 0;
    int          cyc = 0;
    int          gcyc = 0;
    int          lp, cp, tp;
    int          zero_w, trap_v;

    acc16_core u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we)
    );

    always #5 clk = ~clk;

    // Memory with one cycle of read latency
    always @(posedge clk) begin
        mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 16'h0000;
        if (mem_we) mem[mem_addr] = mem_wdata;
    end

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    // Watchdog
    always @(posedge clk) begin
        gcyc <= gcyc + 1;
        if (gcyc > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected under 150000", gcyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Monitor: compare each write against the scoreboard
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL unexpected write: actual addr %h data %h expected none",
                         mem_addr, mem_wdata);
            end else begin
                wr_item_t e;
                e = exp_q.pop_front();
                if (mem_addr !== e.addr || mem_wdata !== e.data ||
                    (e.cyc >= 0 && cyc != e.cyc)) begin
                    errors++;
                    $display("FAIL %s: actual addr %h data %h cycle %0d expected addr %h data %h cycle %0d",
                             e.req, mem_addr, mem_wdata, cyc, e.addr, e.data, e.cyc);
                end
            end
        end
    end

    function automatic int cnst(input logic [15:0] v);
        int a;
        a = cp;
        mem[a[15:0]] = v;
        cp++;
        return a;
    endfunction

    task automatic ins(input logic [3:0] op, input int dir);
        mem[lp[15:0]] = {op, dir[11:0]};
        lp++;
    endtask

    task automatic push(input logic [15:0] a, input logic [15:0] v, input int c, input string r);
        wr_item_t e;
        e.addr = a; e.data = v; e.cyc = c; e.req = r;
        exp_q.push_back(e);
    endtask

    task automatic ldc(input logic [15:0] v);
        ins(K_LDC, cnst(v));
    endtask

    task automatic dump_at(input logic [15:0] tgt, input logic [15:0] v, input string r);
        ins(K_TAT, 0);
        ins(K_STI, cnst(tgt));
        push(tgt, v, -1, r);
    endtask

    task automatic dump(input logic [15:0] v, input string r);
        dump_at(tp[15:0], v, r);
        tp++;
    endtask

    // Carry shown as bit 15 of a stored word
    task automatic dump_c(input logic [15:0] v, input string r);
        ins(K_LDK, zero_w);
        ins(K_RRC, 0);
        dump(v, r);
    endtask

    // Leaves A=1, C=1
    task automatic set_c();
        ldc(16'hFFFF);
        ins(K_ADD, cnst(16'h0002));
    endtask

    task automatic trap();
        ins(K_STI, 'hE10);
    endtask

    task automatic begin_test();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        mem.delete();
        exp_q.delete();
        lp = 0; cp = 'h100; tp = 'h400;
        mem[16'h0E00] = {K_STI, 12'hE10};
        mem[16'h0E10] = 16'hDEAD;
        zero_w = cnst(16'h0000);
        trap_v = cnst(16'h0E00);
    endtask

    task automatic run_test();
        int v;
        v = cnst(lp[15:0]);
        ins(K_LDC, zero_w);
        ins(K_JCC, v);
        @(negedge clk);
        checks++;
        if (mem_we !== 1'b0) begin
            errors++;
            $display("FAIL R1: actual we %b in reset expected 0", mem_we);
        end
        #1 rst_n = 1'b1;
        #1;
        checks++;
        if (mem_addr !== 16'h0000 || mem_we !== 1'b0) begin
            errors++;
            $display("FAIL R1: actual first addr %h we %b expected 0000 0", mem_addr, mem_we);
        end
        for (int i = 0; i < 3000 && exp_q.size() != 0; i++) @(negedge clk);
        while (exp_q.size() != 0) begin
            wr_item_t e;
            e = exp_q.pop_front();
            checks++;
            errors++;
            $display("FAIL %s: actual no write expected addr %h data %h", e.req, e.addr, e.data);
        end
        repeat (30) @(negedge clk);
        rst_n = 1'b0;
    endtask

    initial begin
        int v;
        // Reset values, jump conditions at reset, store timing
        begin_test();
        ins(K_STI, cnst(16'h0200));
        push(16'h0200, 16'h0000, 2, "R1");
        ins(K_TAT, 0);
        ins(K_STI, cnst(16'h0201));
        push(16'h0201, 16'h0000, 7, "R13");
        ins(K_JNZ, trap_v);
        v = cnst(0);
        ins(K_JCC, v);
        trap();
        mem[v[15:0]] = lp[15:0];
        dump(16'h0000, "R1");
        run_test();

        // Add
        begin_test();
        ldc(16'h1234); ins(K_ADD, cnst(16'h4321));
        dump(16'h5555, "R3"); dump_c(16'h0000, "R3");
        set_c();
        dump(16'h0001, "R3"); dump_c(16'h8000, "R3");
        run_test();

        // Subtract with borrow
        begin_test();
        ldc(16'h0003); ins(K_SUB, cnst(16'h0005));
        dump(16'hFFFE, "R4");
        ins(K_LDK, cnst(16'h0010)); ins(K_SUB, cnst(16'h0003));
        dump(16'h000C, "R4"); dump_c(16'h0000, "R4");
        ldc(16'h0010); ins(K_SUB, cnst(16'h0003));
        dump(16'h000D, "R4");
        run_test();

        // Logic operations keep carry
        begin_test();
        set_c();
        ins(K_LDK, cnst(16'hF0F0));
        ins(K_XOR, cnst(16'hFF00)); dump(16'h0FF0, "R5");
        ins(K_OR,  cnst(16'h000F)); dump(16'h0FFF, "R5");
        ins(K_AND, cnst(16'h00FF)); dump(16'h00FF, "R5");
        dump_c(16'h8000, "R5");
        run_test();

        // Rotate through carry
        begin_test();
        set_c();
        ins(K_LDK, cnst(16'h0003));
        ins(K_RRC, 0); dump(16'h8001, "R6");
        ins(K_RRC, 0); dump(16'hC000, "R6");
        ins(K_RRC, 0); dump(16'hE000, "R6");
        ins(K_RRC, 0); dump(16'h7000, "R6");
        run_test();

        // Two loads
        begin_test();
        set_c();
        ins(K_LDK, cnst(16'h1111)); dump(16'h1111, "R7"); dump_c(16'h8000, "R7");
        set_c();
        ldc(16'h2222); dump(16'h2222, "R7"); dump_c(16'h0000, "R7");
        run_test();

        // Conditional jumps and zero flag
        begin_test();
        ldc(16'h0005);
        v = cnst(0);
        ins(K_JCC, v); trap();
        mem[v[15:0]] = lp[15:0];
        ldc(16'h00A1); dump(16'h00A1, "R9");
        set_c();
        ins(K_JCC, trap_v); dump(16'h0001, "R9");
        ldc(16'h0000);
        ins(K_JNZ, trap_v); dump(16'h0000, "R10");
        ldc(16'h0007);
        v = cnst(0);
        ins(K_JNZ, v); trap();
        mem[v[15:0]] = lp[15:0];
        dump(16'h0007, "R10");
        ldc(16'h00F0); ins(K_AND, cnst(16'h0F00));
        ins(K_JNZ, trap_v); dump(16'h0000, "R12");
        ldc(16'h0001); ins(K_RRC, 0);
        ins(K_JNZ, trap_v); dump(16'h0000, "R12");
        run_test();

        // Indirect load/store over 64K, direct field zero extension
        begin_test();
        mem[16'h9ABC] = 16'h4242;
        set_c();
        ins(K_LDI, cnst(16'h9ABC));
        dump_at(16'hC003, 16'h4242, "R8");
        dump(16'h4242, "R11");
        dump_c(16'h8000, "R11");
        mem[16'h0300] = 16'h1111;
        mem[16'h1300] = 16'h7777;
        ins(K_LDC, 'h300); dump(16'h1111, "R2");
        run_test();

        // Spare opcodes do nothing
        begin_test();
        set_c();
        ins(K_LDK, cnst(16'h0033));
        ins(4'd13, zero_w); ins(4'd14, zero_w); ins(4'd15, zero_w);
        dump(16'h0033, "R14"); dump_c(16'h8000, "R14");
        run_test();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule